// File: doc/BRIEF.md
# Serial Character Transmitter with Inter-Character Pause and Line Direction Control

This block turns bytes into asynchronous serial characters for one port. A byte arrives over a ready/valid handshake. The block frames it with a low start bit, 5 to 8 data bits sent least significant bit first, an optional parity bit, and one, one-and-a-half or two stop bits. After each character it holds the line idle for a programmable number of bit periods before it takes the next byte. Bit timing comes from an oversampling tick enable. Each bit lasts `OVS` ticks, which gives the resolution needed for half a stop bit.

Two outputs serve the transceiver. The direction output switches a half-duplex transceiver between driving and listening. Its polarity is selectable, and it can be switched off. The RTS output follows either a manual request or, in automatic mode, whether a byte is waiting or being sent. Its active level is selectable. A break input forces the line low for as long as it is held.

Every configuration field is a plain input decoded by the surrounding logic. That logic's reset value for the pause field is 0x24. The line format, parity and pause are captured when a byte is accepted. Break, direction mode and RTS controls take effect at once.

Top module: `uart_gap_tx`

## Requirements
- R1: After reset the serial line is 1, `in_ready` is 1, and with RTS controls all 0 the `rts` output is 1.
- R2: A byte is taken on a clock edge where `in_valid` and `in_ready` are both 1. `in_ready` goes low on the next clock and rises again exactly T clocks after the accepting edge when ticks arrive every clock. T is the whole character time in ticks, including stop bits and pause.
- R3: The line shows, in order: a 0 start bit, data bits least significant first, optional parity, then stop bits. Each bit lasts `OVS` ticks. The length field `cfg_len` encodes 0=5, 1=6, 2=7 and 3=8 data bits.
- R4: With `cfg_par_en`=1 and `cfg_par_force`=0, the parity bit makes the count of ones over data plus parity even when `cfg_par_even`=1, and odd when `cfg_par_even`=0.
- R5: With `cfg_par_en`=1 and `cfg_par_force`=1, the parity bit is fixed: 0 when `cfg_par_even`=1 and 1 when `cfg_par_even`=0, whatever the data.
- R6: With `cfg_stop_ext`=0 the stop part is `OVS` ticks. With `cfg_stop_ext`=1 it is 1.5*`OVS` ticks for 5-bit data and 2*`OVS` ticks for 6 to 8 bits.
- R7: After the stop bits the line stays 1 for `cfg_gap`*`OVS` ticks before the block is ready again. A waiting byte starts exactly one clock after that pause ends. A pause of 0 adds no idle ticks.
- R8: While `cfg_brk`=1 the line is 0, from the next clock onward. Character timing and the handshake are not changed by it.
- R9: `cfg_dir_mode` selects the direction behaviour: 2'b00 or 2'b01 holds `dir` at 0, 2'b11 drives `dir` high while transmitting, and 2'b10 drives `dir` low while transmitting and high otherwise.
- R10: The active direction level appears one clock before the start bit shows on the line. It holds until the last pause tick has left the line and is released on the next clock.
- R11: With `cfg_rts_auto`=1 the RTS request is active while `in_valid` is 1 or a character is in progress. With `cfg_rts_auto`=0 it follows `cfg_rts_man`. The `rts` pin equals the request when `cfg_rts_hi`=1 and its inverse when `cfg_rts_hi`=0, one clock later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | Oversampling tick enable, `OVS` per bit |
| in_valid | input | 1 | Byte offered |
| in_ready | output | 1 | Block can take a byte |
| in_data | input | MAX_BITS | Byte to send, least significant bit first |
| cfg_len | input | 2 | Data length code, 0=5 .. 3=8 bits |
| cfg_par_en | input | 1 | Parity bit present |
| cfg_par_even | input | 1 | Even parity select (also selects the forced value) |
| cfg_par_force | input | 1 | Send a fixed parity value |
| cfg_stop_ext | input | 1 | Extended stop (1.5 or 2 bits) |
| cfg_gap | input | GAP_W | Pause after each character, in bit periods |
| cfg_brk | input | 1 | Force the line low |
| cfg_dir_mode | input | 2 | Direction output mode |
| cfg_rts_auto | input | 1 | RTS follows the transmit state |
| cfg_rts_man | input | 1 | Manual RTS request |
| cfg_rts_hi | input | 1 | RTS active level is high |
| txd | output | 1 | Serial line |
| dir | output | 1 | Transceiver direction |
| rts | output | 1 | Request-to-send pin |

## Verification
Several properties are checked on every cycle by the assertions. The handshake drops after each acceptance. The data index and tick timer stay within their limits. Break forces the line low. A low line outside break always has the direction output active in transmit-high mode. The disabled direction mode keeps `dir` low. Automatic RTS reacts to a waiting byte with the programmed level.

Other behaviour only the bench scenarios can show, because it needs whole frames decoded from the line. This covers bit order, the width of each length code, parity values, the exact lengths of the stop bits and the pause, back-to-back start spacing, and the points where the direction output is raised and released around a complete character.

// File: rtl/uart_gap_pkg.sv
package uart_gap_pkg;

  typedef enum logic [2:0] {
    ST_IDLE   = 3'd0,
    ST_START  = 3'd1,
    ST_DATA   = 3'd2,
    ST_PARITY = 3'd3,
    ST_STOP   = 3'd4,
    ST_GAP    = 3'd5
  } tx_state_e;

  // Direction output modes; the two upper codes are the active ones.
  typedef enum logic [1:0] {
    DIR_OFF   = 2'b00,
    DIR_RSV   = 2'b01,
    DIR_HI_RX = 2'b10,
    DIR_HI_TX = 2'b11
  } dir_mode_e;

endpackage

// File: rtl/txg_parity.sv
module txg_parity #(
  parameter int MAX_BITS = 8
) (
  input  logic [MAX_BITS-1:0] data,
  input  logic [1:0]          len,
  input  logic                even_sel,
  input  logic                force_sel,
  output logic                par_bit
);
  localparam int MIN_BITS = MAX_BITS - 3;

  logic [MAX_BITS-1:0] used;

  // Keep only the bits that belong to the selected character length.
  for (genvar i = 0; i < MAX_BITS; i++) begin : g_mask
    if (i < MIN_BITS) begin : g_always
      assign used[i] = data[i];
    end else begin : g_opt
      assign used[i] = data[i] & (32'(len) >= 32'(i - MIN_BITS + 1));
    end
  end

  always_comb begin
    if (force_sel)     par_bit = ~even_sel;
    else if (even_sel) par_bit = ^used;
    else               par_bit = ~(^used);
  end
endmodule

// File: rtl/txg_frame.sv
module txg_frame
  import uart_gap_pkg::*;
#(
  parameter int OVS      = 16,
  parameter int MAX_BITS = 8,
  parameter int GAP_W    = 8
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                tick,
  input  logic                in_valid,
  input  logic [MAX_BITS-1:0] in_data,
  input  logic [1:0]          len,
  input  logic                par_en,
  input  logic                par_bit,
  input  logic                stop_ext,
  input  logic [GAP_W-1:0]    gap,
  output logic                in_ready,
  output logic                accept,
  output logic                active,
  output logic                line
);
  localparam int MIN_BITS = MAX_BITS - 3;
  localparam int IW       = $clog2(MAX_BITS);
  localparam int CW       = GAP_W + $clog2(OVS) + 1;
  localparam logic [CW-1:0] BIT_LIM  = CW'(OVS);
  localparam logic [CW-1:0] HALF_LIM = CW'((OVS * 3) / 2);
  localparam logic [CW-1:0] TWO_LIM  = CW'(OVS * 2);

  tx_state_e           state_q, state_d;
  logic [CW-1:0]       cnt_q, lim_c;
  logic [CW-1:0]       stop_lim_q, gap_lim_q;
  logic                gap_zero_q;
  logic [MAX_BITS-1:0] sh_q;
  logic [IW-1:0]       idx_q, last_q;
  logic                par_q, par_en_q, rdy_q;
  logic                bit_end;

  assign in_ready = rdy_q;
  assign accept   = in_valid & rdy_q;
  assign active   = (state_q != ST_IDLE);

  always_comb begin
    case (state_q)
      ST_STOP: lim_c = stop_lim_q;
      ST_GAP:  lim_c = gap_lim_q;
      default: lim_c = BIT_LIM;
    endcase
  end

  assign bit_end = tick & (cnt_q == lim_c - CW'(1));

  always_comb begin
    state_d = state_q;
    case (state_q)
      ST_IDLE:   if (accept) state_d = ST_START;
      ST_START:  if (bit_end) state_d = ST_DATA;
      ST_DATA:   if (bit_end && idx_q == last_q)
                   state_d = par_en_q ? ST_PARITY : ST_STOP;
      ST_PARITY: if (bit_end) state_d = ST_STOP;
      ST_STOP:   if (bit_end) state_d = gap_zero_q ? ST_IDLE : ST_GAP;
      ST_GAP:    if (bit_end) state_d = ST_IDLE;
      default:   state_d = ST_IDLE;
    endcase
  end

  always_comb begin
    case (state_q)
      ST_START:  line = 1'b0;
      ST_DATA:   line = sh_q[0];
      ST_PARITY: line = par_q;
      default:   line = 1'b1;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q    <= ST_IDLE;
      cnt_q      <= '0;
      stop_lim_q <= BIT_LIM;
      gap_lim_q  <= '0;
      gap_zero_q <= 1'b1;
      sh_q       <= '0;
      idx_q      <= '0;
      last_q     <= '0;
      par_q      <= 1'b0;
      par_en_q   <= 1'b0;
      rdy_q      <= 1'b0;
    end else begin
      state_q <= state_d;
      rdy_q   <= (state_d == ST_IDLE);

      if (state_q == ST_IDLE)  cnt_q <= '0;
      else if (bit_end)        cnt_q <= '0;
      else if (tick)           cnt_q <= cnt_q + CW'(1);

      if (accept) begin
        sh_q       <= in_data;
        idx_q      <= '0;
        last_q     <= IW'(MIN_BITS - 1) + IW'(len);
        par_q      <= par_bit;
        par_en_q   <= par_en;
        gap_lim_q  <= CW'(gap) * BIT_LIM;
        gap_zero_q <= (gap == '0);
        if (!stop_ext)          stop_lim_q <= BIT_LIM;
        else if (len == 2'd0)   stop_lim_q <= HALF_LIM;
        else                    stop_lim_q <= TWO_LIM;
      end else if (state_q == ST_DATA && bit_end) begin
        sh_q  <= sh_q >> 1;
        idx_q <= idx_q + IW'(1);
      end
    end
  end

  // R2: an accepted byte closes the handshake on the next clock
  assert_ready_drop_R2: assert property (@(posedge clk) disable iff (rst)
    accept |=> !in_ready);

  // R3: the data index never runs past the selected length
  assert_index_range_R3: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_DATA) |-> (idx_q <= last_q));

  // R7: the tick timer stays inside the current period limit
  assert_timer_range_R7: assert property (@(posedge clk) disable iff (rst)
    active |-> (cnt_q < lim_c));
endmodule

// File: rtl/txg_line_ctl.sv
module txg_line_ctl
  import uart_gap_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       line,
  input  logic       brk,
  input  logic       accept,
  input  logic       active,
  input  logic       in_valid,
  input  logic [1:0] dir_mode,
  input  logic       rts_auto,
  input  logic       rts_man,
  input  logic       rts_hi,
  output logic       txd,
  output logic       dir,
  output logic       rts
);
  logic busy, rts_req;

  assign busy    = active | accept;
  assign rts_req = rts_auto ? (in_valid | active) : rts_man;

  always_ff @(posedge clk) begin
    if (rst) begin
      txd <= 1'b1;
      dir <= 1'b0;
      rts <= 1'b1;
    end else begin
      txd <= brk ? 1'b0 : line;
      case (dir_mode)
        DIR_HI_TX: dir <= busy;
        DIR_HI_RX: dir <= ~busy;
        default:   dir <= 1'b0;
      endcase
      rts <= rts_hi ? rts_req : ~rts_req;
    end
  end

  // R8: break forces the line low one clock later
  assert_break_low_R8: assert property (@(posedge clk) disable iff (rst)
    brk |=> !txd);

  // R10: a low line outside break always has the transmit direction set
  assert_dir_early_R10: assert property (@(posedge clk) disable iff (rst)
    (!txd && !$past(brk) && $past(dir_mode) == DIR_HI_TX) |-> dir);

  // R9: disabled mode keeps the direction output low
  assert_dir_off_R9: assert property (@(posedge clk) disable iff (rst)
    ($past(dir_mode) == DIR_OFF) |-> !dir);

  // R11: automatic RTS reacts to a waiting byte at the programmed level
  assert_rts_auto_R11: assert property (@(posedge clk) disable iff (rst)
    (rts_auto && in_valid) |=> (rts == $past(rts_hi)));
endmodule

// File: rtl/uart_gap_tx.sv
module uart_gap_tx #(
  parameter int OVS      = 16,
  parameter int MAX_BITS = 8,
  parameter int GAP_W    = 8
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                tick,
  input  logic                in_valid,
  output logic                in_ready,
  input  logic [MAX_BITS-1:0] in_data,
  input  logic [1:0]          cfg_len,
  input  logic                cfg_par_en,
  input  logic                cfg_par_even,
  input  logic                cfg_par_force,
  input  logic                cfg_stop_ext,
  input  logic [GAP_W-1:0]    cfg_gap,
  input  logic                cfg_brk,
  input  logic [1:0]          cfg_dir_mode,
  input  logic                cfg_rts_auto,
  input  logic                cfg_rts_man,
  input  logic                cfg_rts_hi,
  output logic                txd,
  output logic                dir,
  output logic                rts
);
  logic par_bit, accept, active, line;

  txg_parity #(.MAX_BITS(MAX_BITS)) u_par (
    .data      (in_data),
    .len       (cfg_len),
    .even_sel  (cfg_par_even),
    .force_sel (cfg_par_force),
    .par_bit   (par_bit)
  );

  txg_frame #(.OVS(OVS), .MAX_BITS(MAX_BITS), .GAP_W(GAP_W)) u_frame (
    .clk      (clk),
    .rst      (rst),
    .tick     (tick),
    .in_valid (in_valid),
    .in_data  (in_data),
    .len      (cfg_len),
    .par_en   (cfg_par_en),
    .par_bit  (par_bit),
    .stop_ext (cfg_stop_ext),
    .gap      (cfg_gap),
    .in_ready (in_ready),
    .accept   (accept),
    .active   (active),
    .line     (line)
  );

  txg_line_ctl u_line (
    .clk      (clk),
    .rst      (rst),
    .line     (line),
    .brk      (cfg_brk),
    .accept   (accept),
    .active   (active),
    .in_valid (in_valid),
    .dir_mode (cfg_dir_mode),
    .rts_auto (cfg_rts_auto),
    .rts_man  (cfg_rts_man),
    .rts_hi   (cfg_rts_hi),
    .txd      (txd),
    .dir      (dir),
    .rts      (rts)
  );
endmodule

// File: tb/tb_uart_gap_tx.sv
module tb_uart_gap_tx;
  localparam int OVS = 4;
  localparam int LOGN = 8192;

  logic clk = 1'b0, rst = 1'b1;
  logic in_valid = 1'b0, in_ready;
  logic [7:0] in_data = '0;
  logic [1:0] cfg_len = 2'd3;
  logic cfg_par_en = 0, cfg_par_even = 0, cfg_par_force = 0, cfg_stop_ext = 0;
  logic [7:0] cfg_gap = '0;
  logic cfg_brk = 0;
  logic [1:0] cfg_dir_mode = 2'b00;
  logic cfg_rts_auto = 0, cfg_rts_man = 0, cfg_rts_hi = 0;
  logic txd, dir, rts;

  int total = 0, bad = 0, cyc = 0;
  bit finished = 0;
  logic txl [0:LOGN-1];
  logic rdyl[0:LOGN-1];
  logic dirl[0:LOGN-1];

  always #2.5 clk = ~clk;

  uart_gap_tx #(.OVS(OVS), .MAX_BITS(8), .GAP_W(8)) dut (
    .clk(clk), .rst(rst), .tick(1'b1), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .cfg_len(cfg_len), .cfg_par_en(cfg_par_en),
    .cfg_par_even(cfg_par_even), .cfg_par_force(cfg_par_force),
    .cfg_stop_ext(cfg_stop_ext), .cfg_gap(cfg_gap), .cfg_brk(cfg_brk),
    .cfg_dir_mode(cfg_dir_mode), .cfg_rts_auto(cfg_rts_auto),
    .cfg_rts_man(cfg_rts_man), .cfg_rts_hi(cfg_rts_hi),
    .txd(txd), .dir(dir), .rts(rts)
  );

  // Log index k holds the outputs just after the k-th rising edge.
  always @(posedge clk) begin
    #1;
    if (cyc < LOGN) begin
      txl[cyc] = txd; rdyl[cyc] = in_ready; dirl[cyc] = dir;
    end
    cyc++;
  end

  task automatic check(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int bits_at(input int f, input int n);
    int v = 0;
    for (int k = 0; k < n; k++) v |= int'(txl[f + 2 + OVS*(1+k)]) << k;
    return v;
  endfunction

  function automatic int all_high(input int from, input int cnt);
    for (int i = from; i < from + cnt; i++) if (txl[i] !== 1'b1) return 0;
    return 1;
  endfunction

  function automatic int first_ready(input int from);
    for (int i = from; i < LOGN; i++) if (rdyl[i] === 1'b1) return i;
    return -1;
  endfunction

  // Offer a byte; return the log index of the accepting edge.
  task automatic send(input logic [7:0] b, output int a);
    @(negedge clk);
    in_valid = 1; in_data = b;
    while (!in_ready) @(negedge clk);
    @(negedge clk);
    a = cyc - 1;
    in_valid = 0;
  endtask

  task automatic send_pair(input logic [7:0] b1, input logic [7:0] b2,
                           output int a1, output int a2);
    @(negedge clk);
    in_valid = 1; in_data = b1;
    while (!in_ready) @(negedge clk);
    @(negedge clk);
    a1 = cyc - 1; in_data = b2;
    while (!in_ready) @(negedge clk);
    @(negedge clk);
    a2 = cyc - 1; in_valid = 0;
  endtask

  task automatic wait_idle();
    @(negedge clk);
    while (!in_ready) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  task automatic t_reset();
    @(negedge clk);
    check("R1 idle line", int'(txd), 1);
    check("R1 ready", int'(in_ready), 1);
    check("R1 rts inactive", int'(rts), 1);
  endtask

  task automatic t_basic();
    int a, f, r;
    cfg_len = 3; cfg_par_en = 0; cfg_stop_ext = 0; cfg_gap = 0;
    send(8'hA5, a); wait_idle();
    f = a + 1;
    check("R3 start bit", int'(txl[f]), 0);
    check("R3 data lsb first", bits_at(f, 8), 'hA5);
    check("R6 one stop", all_high(f + 36, 4), 1);
    check("R2 ready low after accept", int'(rdyl[a]), 0);
    r = first_ready(a);
    check("R2 ready return T", r - a, 40);
  endtask

  task automatic t_lengths();
    int a, f;
    for (int L = 0; L < 3; L++) begin
      cfg_len = 2'(L);
      send(8'hD6, a); wait_idle();
      f = a + 1;
      check("R3 length code data", bits_at(f, 5 + L), 'hD6 & ((1 << (5 + L)) - 1));
      check("R3 stop after length", int'(txl[f + 2 + OVS*(6 + L)]), 1);
      check("R3 character time", first_ready(a) - a, OVS*(6 + L) + OVS);
    end
  endtask

  task automatic t_parity();
    int a, f;
    cfg_par_en = 1; cfg_par_force = 0; cfg_len = 2;
    cfg_par_even = 1; send(8'h5B, a); wait_idle(); f = a + 1;
    check("R4 even parity 7b", int'(txl[f + 2 + OVS*8]), 1);
    cfg_par_even = 0; send(8'h5B, a); wait_idle(); f = a + 1;
    check("R4 odd parity 7b", int'(txl[f + 2 + OVS*8]), 0);
    cfg_len = 3;
    cfg_par_even = 0; send(8'h00, a); wait_idle(); f = a + 1;
    check("R4 odd parity zero", int'(txl[f + 2 + OVS*9]), 1);
    check("R4 parity frame time", first_ready(a) - a, OVS*11);
  endtask

  task automatic t_force();
    int a, f;
    cfg_par_en = 1; cfg_par_force = 1; cfg_len = 3;
    cfg_par_even = 1; send(8'h01, a); wait_idle(); f = a + 1;
    check("R5 forced zero", int'(txl[f + 2 + OVS*9]), 0);
    cfg_par_even = 0; send(8'h03, a); wait_idle(); f = a + 1;
    check("R5 forced one", int'(txl[f + 2 + OVS*9]), 1);
    cfg_par_en = 0; cfg_par_force = 0;
  endtask

  task automatic t_stops();
    int a1, a2;
    cfg_gap = 0;
    cfg_len = 0; cfg_stop_ext = 1; send_pair(8'h11, 8'h12, a1, a2); wait_idle();
    check("R6 one and half stop 5b", a2 - a1, 31);
    check("R6 half stop line high", all_high(a1 + 1 + 24, 6), 1);
    cfg_len = 3; cfg_stop_ext = 1; send_pair(8'h21, 8'h22, a1, a2); wait_idle();
    check("R6 two stop 8b", a2 - a1, 45);
    cfg_len = 0; cfg_stop_ext = 0; send_pair(8'h31, 8'h32, a1, a2); wait_idle();
    check("R6 one stop 5b", a2 - a1, 29);
    cfg_len = 3;
  endtask

  task automatic t_gap();
    int a1, a2, a;
    cfg_stop_ext = 0;
    cfg_gap = 3; send_pair(8'h41, 8'h42, a1, a2); wait_idle();
    check("R7 gap spacing", a2 - a1, 53);
    check("R7 gap line idle", all_high(a1 + 1 + 36, 16), 1);
    cfg_gap = 8'h24; send(8'h43, a); wait_idle();
    check("R7 reset default gap", first_ready(a) - a, 40 + 36*OVS);
    cfg_gap = 0;
  endtask

  task automatic t_break();
    int a;
    @(negedge clk); cfg_brk = 1;
    repeat (2) @(negedge clk);
    check("R8 break idle line low", int'(txd), 0);
    repeat (4) @(negedge clk);
    check("R8 break held low", int'(txd), 0);
    cfg_brk = 0; repeat (2) @(negedge clk);
    check("R8 release", int'(txd), 1);
    send(8'hFF, a);
    repeat (9) @(negedge clk); cfg_brk = 1;
    repeat (4) @(negedge clk);
    check("R8 break in frame", int'(txd), 0);
    cfg_brk = 0;
    wait_idle();
    check("R8 timing unchanged", first_ready(a) - a, 40);
  endtask

  task automatic t_dir();
    int a, ok;
    cfg_gap = 2;
    cfg_dir_mode = 2'b11; repeat (2) @(negedge clk);
    send(8'h5A, a); wait_idle();
    check("R9 tx-high idle low", int'(dirl[a - 1]), 0);
    check("R10 dir before start", int'(dirl[a]) * 10 + int'(txl[a]), 11);
    ok = 1;
    for (int i = a; i <= a + 48; i++) if (dirl[i] !== 1'b1) ok = 0;
    check("R10 dir held through gap", ok, 1);
    check("R10 dir released", int'(dirl[a + 49]), 0);
    cfg_dir_mode = 2'b10; repeat (2) @(negedge clk);
    check("R9 rx-high idle", int'(dir), 1);
    send(8'h5A, a); wait_idle();
    check("R9 rx-high during frame", int'(dirl[a + 20]), 0);
    cfg_dir_mode = 2'b00; send(8'h5A, a); wait_idle();
    check("R9 off during frame", int'(dirl[a + 20]), 0);
    cfg_gap = 0;
  endtask

  task automatic t_rts();
    cfg_rts_auto = 1; cfg_rts_hi = 0;
    repeat (2) @(negedge clk);
    check("R11 auto idle inactive", int'(rts), 1);
    in_data = 8'h77; in_valid = 1;
    @(negedge clk);
    check("R11 auto pending active low", int'(rts), 0);
    in_valid = 0;
    repeat (10) @(negedge clk);
    check("R11 auto during frame", int'(rts), 0);
    wait_idle();
    check("R11 auto released", int'(rts), 1);
    cfg_rts_auto = 0; cfg_rts_hi = 1; cfg_rts_man = 1;
    repeat (2) @(negedge clk);
    check("R11 manual active high", int'(rts), 1);
    cfg_rts_man = 0; repeat (2) @(negedge clk);
    check("R11 manual off", int'(rts), 0);
  endtask

  initial begin
    repeat (4) @(posedge clk);
    @(negedge clk); rst = 0;
    t_reset();
    t_basic();
    t_lengths();
    t_parity();
    t_force();
    t_stops();
    t_gap();
    t_break();
    t_dir();
    t_rts();
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule